// File: doc/BRIEF.md
# UART Hardware Flow-Control Controller

This block is the flow-control and modem-signal layer placed next to a UART transmitter and receiver. It does not shift bits or generate baud timing. It decides when the far end may send to this node, and when the local transmitter may start a new character. It also watches the modem status lines for level changes and raises an interrupt for them.

A two-bit mode input picks the behaviour. In handshaking mode the ready-to-send output reflects the local receiver. It goes high (not ready) when the receiver is disabled or when a DMA engine reports that its receive buffer is full. Software releases that full flag by handing the DMA a fresh buffer. A high clear-to-send input stops the transmitter from starting any new character, but a character already being sent always finishes. In modem mode the block acts as the terminal side of the link. It drives DTR and RTS from software control bits and keeps one change flag for each of CTS, DSR, DCD and RI. The change flags clear when software reads the status. Each flag has its own interrupt mask bit.

Top module: `uart_flowctl`

## Requirements
- R1: `mode_i` encoding: 2'b10 is handshaking, 2'b11 is modem, and 2'b00 and 2'b01 are normal mode.
- R2: In handshaking mode `rts_o` is high one clock after `rx_enable_i` is low or `rxbuf_full_o` is high, and low one clock after both conditions are gone.
- R3: `rxbuf_full_o` is set one clock after a `rxbuf_full_pulse_i` cycle and cleared one clock after a `rxbuf_clr_i` cycle. When both occur in the same cycle, the set wins. After a clear with the receiver enabled in handshaking mode, `rts_o` falls two clocks after the clear cycle.
- R4: `tx_start_o` is high when `tx_req_i` is high, `tx_busy_i` is low and CTS is not blocking. In handshaking and modem modes, CTS blocks starting two clocks after `cts_i` goes high, because of a two-flop synchronizer. `tx_start_o` is never high while `tx_busy_i` is high, so a character in flight is never affected.
- R5: In handshaking and modem modes, a level change on `cts_i` sets status bit 3 three clocks after the change.
- R6: In modem mode, level changes on `ri_i`, `dsr_i` and `dcd_i` set status bits 0, 1 and 2 three clocks after the change. In the other modes these three inputs set no flag. `line_state_o` shows the synchronized levels in the same bit order, two clocks after a change.
- R7: A cycle with `status_rd_i` high clears every status bit at the next clock, except a bit whose input changes in that same cycle, which stays set.
- R8: `irq_o` is a register holding the OR over (status bit AND `irq_mask_i` bit), so it follows the status by one clock.
- R9: In modem mode `dtr_o` and `rts_o` follow `dtr_ctrl_i` and `rts_ctrl_i` one clock later. Outside modem mode `dtr_o` is held high.
- R10: In normal mode `rts_o` follows `rts_ctrl_i` one clock later. CTS neither blocks `tx_start_o` nor sets a status bit.
- R11: While `rst_n` is low: `rts_o` and `dtr_o` are high, and `status_o`, `irq_o` and `rxbuf_full_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Operating mode select |
| rx_enable_i | input | 1 | Local receiver enabled |
| rxbuf_full_pulse_i | input | 1 | DMA receive-buffer-full pulse |
| rxbuf_clr_i | input | 1 | Software hands DMA a new buffer |
| rts_ctrl_i | input | 1 | Software RTS level |
| dtr_ctrl_i | input | 1 | Software DTR level |
| status_rd_i | input | 1 | Status read strobe (clears change flags) |
| irq_mask_i | input | 4 | Per-flag interrupt enable |
| cts_i | input | 1 | Clear-to-send line, asynchronous |
| dsr_i | input | 1 | Data-set-ready line, asynchronous |
| dcd_i | input | 1 | Carrier-detect line, asynchronous |
| ri_i | input | 1 | Ring-indicator line, asynchronous |
| tx_req_i | input | 1 | Transmitter has a character ready |
| tx_busy_i | input | 1 | Transmitter is shifting a character |
| tx_start_o | output | 1 | Permission to start the next character |
| rts_o | output | 1 | Ready-to-send line |
| dtr_o | output | 1 | Terminal-ready line |
| rxbuf_full_o | output | 1 | Receive-buffer-full flag |
| status_o | output | 4 | Change flags: bit0 RI, bit1 DSR, bit2 DCD, bit3 CTS |
| line_state_o | output | 4 | Synchronized line levels, same order |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The assertions assume that `status_rd_i`, `rxbuf_clr_i` and `rxbuf_full_pulse_i` are single-cycle strobes that are synchronous to `clk`. They also assume that the transmitter keeps `tx_busy_i` high for the whole character. Only the four modem lines are treated as asynchronous. The stimulus changes each of those lines only once every few cycles, so every edge passes through the synchronizer before the next one arrives. The stimulus also raises a status read in exactly the cycle in which a pending DSR change reaches the flag logic.

// File: rtl/uart_fc_pkg.sv
package uart_fc_pkg;

  typedef enum logic [1:0] {
    FC_MODE_NORMAL    = 2'b00,
    FC_MODE_RSVD      = 2'b01,
    FC_MODE_HANDSHAKE = 2'b10,
    FC_MODE_MODEM     = 2'b11
  } fc_mode_e;

  localparam int unsigned FC_NUM_LINES = 4;
  localparam int unsigned FC_SYNC_STAGES = 2;

  // bit positions inside status / line-state vectors
  localparam int unsigned FC_BIT_RI  = 0;
  localparam int unsigned FC_BIT_DSR = 1;
  localparam int unsigned FC_BIT_DCD = 2;
  localparam int unsigned FC_BIT_CTS = 3;

endpackage

// File: rtl/fc_sync.sv
module fc_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= async_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/fc_change_flags.sv
module fc_change_flags #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] level_i,
  input  logic [WIDTH-1:0] enable_i,
  input  logic             clear_i,
  output logic [WIDTH-1:0] flags_o
);

  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] flag_q, flag_d;
  logic [WIDTH-1:0] chg;

  // edge detect on already-synchronized levels
  assign chg = enable_i & (level_i ^ prev_q);

  always_comb begin
    flag_d = flag_q;
    if (clear_i) flag_d = '0;
    flag_d = flag_d | chg;   // a new event outranks the read
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      flag_q <= '0;
    end else begin
      prev_q <= level_i;
      flag_q <= flag_d;
    end
  end

  assign flags_o = flag_q;

  for (genvar i = 0; i < WIDTH; i++) begin : g_chk
    AST_CHANGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      chg[i] |=> flag_q[i]); // R7
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (clear_i && !chg[i]) |=> !flag_q[i]); // R7
    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[i] && !clear_i) |=> flag_q[i]); // R5
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_q[i] && !enable_i[i]) |=> !flag_q[i]); // R6
  end

endmodule

// File: rtl/fc_irq_gen.sv
module fc_irq_gen #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] flags_i,
  input  logic [WIDTH-1:0] mask_i,
  output logic             irq_o
);

  logic irq_q, irq_d;

  always_comb irq_d = |(flags_i & mask_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_o = irq_q;

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags_i & mask_i) == '0) |=> !irq_o); // R8
  AST_IRQ_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags_i & mask_i) != '0) |=> irq_o); // R8

endmodule

// File: rtl/fc_line_drive.sv
module fc_line_drive
  import uart_fc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  fc_mode_e mode,
  input  logic     rx_enable_i,
  input  logic     buf_full_pulse_i,
  input  logic     buf_clr_i,
  input  logic     rts_ctrl_i,
  input  logic     dtr_ctrl_i,
  output logic     rts_o,
  output logic     dtr_o,
  output logic     buf_full_o
);

  logic full_q, full_d;
  logic rts_q, rts_d;
  logic dtr_q, dtr_d;

  always_comb begin
    full_d = full_q;
    if (buf_clr_i)        full_d = 1'b0;
    if (buf_full_pulse_i) full_d = 1'b1;
  end

  always_comb begin
    unique case (mode)
      FC_MODE_HANDSHAKE: begin
        rts_d = !rx_enable_i || full_q;
        dtr_d = 1'b1;
      end
      FC_MODE_MODEM: begin
        rts_d = rts_ctrl_i;
        dtr_d = dtr_ctrl_i;
      end
      default: begin
        rts_d = rts_ctrl_i;
        dtr_d = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      rts_q  <= 1'b1;
      dtr_q  <= 1'b1;
    end else begin
      full_q <= full_d;
      rts_q  <= rts_d;
      dtr_q  <= dtr_d;
    end
  end

  assign rts_o      = rts_q;
  assign dtr_o      = dtr_q;
  assign buf_full_o = full_q;

  AST_BUF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    buf_full_pulse_i |=> buf_full_o); // R3
  AST_BUF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_clr_i && !buf_full_pulse_i) |=> !buf_full_o); // R3
  AST_HS_RTS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == FC_MODE_HANDSHAKE && !rx_enable_i) |=> rts_o); // R2
  AST_DTR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != FC_MODE_MODEM) |=> dtr_o); // R9

endmodule

// File: rtl/uart_flowctl.sv
module uart_flowctl
  import uart_fc_pkg::*;
#(
  parameter int unsigned NUM_LINES   = FC_NUM_LINES,
  parameter int unsigned SYNC_STAGES = FC_SYNC_STAGES
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           mode_i,
  input  logic                 rx_enable_i,
  input  logic                 rxbuf_full_pulse_i,
  input  logic                 rxbuf_clr_i,
  input  logic                 rts_ctrl_i,
  input  logic                 dtr_ctrl_i,
  input  logic                 status_rd_i,
  input  logic [NUM_LINES-1:0] irq_mask_i,
  input  logic                 cts_i,
  input  logic                 dsr_i,
  input  logic                 dcd_i,
  input  logic                 ri_i,
  input  logic                 tx_req_i,
  input  logic                 tx_busy_i,
  output logic                 tx_start_o,
  output logic                 rts_o,
  output logic                 dtr_o,
  output logic                 rxbuf_full_o,
  output logic [NUM_LINES-1:0] status_o,
  output logic [NUM_LINES-1:0] line_state_o,
  output logic                 irq_o
);

  fc_mode_e             mode;
  logic [NUM_LINES-1:0] raw_lines;
  logic [NUM_LINES-1:0] sync_lines;
  logic [NUM_LINES-1:0] det_en;
  logic                 cts_watch;
  logic                 cts_block;

  assign mode = fc_mode_e'(mode_i);

  always_comb begin
    raw_lines             = '0;
    raw_lines[FC_BIT_RI]  = ri_i;
    raw_lines[FC_BIT_DSR] = dsr_i;
    raw_lines[FC_BIT_DCD] = dcd_i;
    raw_lines[FC_BIT_CTS] = cts_i;
  end

  fc_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (raw_lines),
    .sync_o  (sync_lines)
  );

  assign cts_watch = (mode == FC_MODE_HANDSHAKE) || (mode == FC_MODE_MODEM);

  always_comb begin
    det_en             = '0;
    det_en[FC_BIT_RI]  = (mode == FC_MODE_MODEM);
    det_en[FC_BIT_DSR] = (mode == FC_MODE_MODEM);
    det_en[FC_BIT_DCD] = (mode == FC_MODE_MODEM);
    det_en[FC_BIT_CTS] = cts_watch;
  end

  fc_change_flags #(.WIDTH(NUM_LINES)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .level_i  (sync_lines),
    .enable_i (det_en),
    .clear_i  (status_rd_i),
    .flags_o  (status_o)
  );

  fc_irq_gen #(.WIDTH(NUM_LINES)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .flags_i (status_o),
    .mask_i  (irq_mask_i),
    .irq_o   (irq_o)
  );

  fc_line_drive u_drive (
    .clk              (clk),
    .rst_n            (rst_n),
    .mode             (mode),
    .rx_enable_i      (rx_enable_i),
    .buf_full_pulse_i (rxbuf_full_pulse_i),
    .buf_clr_i        (rxbuf_clr_i),
    .rts_ctrl_i       (rts_ctrl_i),
    .dtr_ctrl_i       (dtr_ctrl_i),
    .rts_o            (rts_o),
    .dtr_o            (dtr_o),
    .buf_full_o       (rxbuf_full_o)
  );

  // only new characters are gated; the busy one runs to completion
  assign cts_block  = cts_watch && sync_lines[FC_BIT_CTS];
  assign tx_start_o = tx_req_i && !tx_busy_i && !cts_block;
  assign line_state_o = sync_lines;

  AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_busy_i |-> !tx_start_o); // R4
  AST_CTS_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    (cts_watch && line_state_o[FC_BIT_CTS]) |-> !tx_start_o); // R4

endmodule

// File: tb/uart_flowctl_tb.sv
module uart_flowctl_tb;

  localparam int SIG_RTS = 0, SIG_DTR = 1, SIG_TXS = 2, SIG_STAT = 3,
                 SIG_IRQ = 4, SIG_BUF = 5, SIG_LINE = 6;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] mode;
  logic       rx_en, buf_pulse, buf_clr, rts_ctrl, dtr_ctrl, st_rd;
  logic [3:0] mask;
  logic       cts, dsr, dcd, ri, tx_req, tx_busy;
  logic       tx_start, rts, dtr, buf_full, irq;
  logic [3:0] status, line_state;

  int cyc = 0;
  int checks = 0;
  int errors = 0;

  int         q_cyc[$];
  int         q_sig[$];
  logic [7:0] q_val[$];
  string      q_req[$];

  always #4 clk = ~clk;  // 125 MHz

  uart_flowctl u_dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .rx_enable_i(rx_en),
    .rxbuf_full_pulse_i(buf_pulse), .rxbuf_clr_i(buf_clr),
    .rts_ctrl_i(rts_ctrl), .dtr_ctrl_i(dtr_ctrl), .status_rd_i(st_rd),
    .irq_mask_i(mask), .cts_i(cts), .dsr_i(dsr), .dcd_i(dcd), .ri_i(ri),
    .tx_req_i(tx_req), .tx_busy_i(tx_busy), .tx_start_o(tx_start),
    .rts_o(rts), .dtr_o(dtr), .rxbuf_full_o(buf_full), .status_o(status),
    .line_state_o(line_state), .irq_o(irq)
  );

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] get_sig(input int sig);
    case (sig)
      SIG_RTS:  return {7'd0, rts};
      SIG_DTR:  return {7'd0, dtr};
      SIG_TXS:  return {7'd0, tx_start};
      SIG_STAT: return {4'd0, status};
      SIG_IRQ:  return {7'd0, irq};
      SIG_BUF:  return {7'd0, buf_full};
      default:  return {4'd0, line_state};
    endcase
  endfunction

  // driver side: expected item lands lat clock edges after now
  task automatic expect_in(input int sig, input logic [7:0] val, input int lat, input string req);
    q_cyc.push_back(cyc + lat);
    q_sig.push_back(sig);
    q_val.push_back(val);
    q_req.push_back(req);
  endtask

  task automatic tick(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      #1;
    end
  endtask

  // monitor side: compare due items at the falling edge
  always @(negedge clk) begin
    for (int i = q_cyc.size() - 1; i >= 0; i--) begin
      if (q_cyc[i] == cyc) begin
        checks++;
        if (get_sig(q_sig[i]) !== q_val[i]) begin
          errors++;
          $display("FAIL %s sig%0d cycle %0d: actual %0h expected %0h",
                   q_req[i], q_sig[i], cyc, get_sig(q_sig[i]), q_val[i]);
        end
        q_cyc.delete(i); q_sig.delete(i); q_val.delete(i); q_req.delete(i);
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 3000) begin
      errors++;
      $display("FAIL watchdog: actual cycle %0d expected end before 3000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; mode = 2'b00; rx_en = 1'b0; buf_pulse = 1'b0; buf_clr = 1'b0;
    rts_ctrl = 1'b1; dtr_ctrl = 1'b1; st_rd = 1'b0; mask = 4'h0;
    cts = 1'b0; dsr = 1'b0; dcd = 1'b0; ri = 1'b0; tx_req = 1'b0; tx_busy = 1'b0;
    tick(1);
    // R11 reset state
    expect_in(SIG_RTS, 8'd1, 1, "R11");
    expect_in(SIG_DTR, 8'd1, 1, "R11");
    expect_in(SIG_STAT, 8'd0, 1, "R11");
    expect_in(SIG_IRQ, 8'd0, 1, "R11");
    expect_in(SIG_BUF, 8'd0, 1, "R11");
    tick(2);
    rst_n = 1'b1;
    tick(2);

    // normal mode: R10, R1, R9
    rts_ctrl = 1'b0; dtr_ctrl = 1'b0;
    expect_in(SIG_RTS, 8'd0, 1, "R10");
    expect_in(SIG_DTR, 8'd1, 1, "R9");
    tick(1);
    cts = 1'b1; tx_req = 1'b1;
    expect_in(SIG_TXS, 8'd1, 3, "R10");
    expect_in(SIG_STAT, 8'd0, 4, "R10");
    tick(4);
    cts = 1'b0;
    tick(4);

    // handshaking mode: R1, R2, R3
    mode = 2'b10; rx_en = 1'b1;
    expect_in(SIG_RTS, 8'd0, 1, "R2");
    tick(3);
    rx_en = 1'b0;
    expect_in(SIG_RTS, 8'd1, 1, "R2");
    tick(1);
    rx_en = 1'b1;
    expect_in(SIG_RTS, 8'd0, 1, "R2");
    tick(1);
    buf_pulse = 1'b1;
    expect_in(SIG_BUF, 8'd1, 1, "R3");
    expect_in(SIG_RTS, 8'd1, 2, "R2");
    tick(1);
    buf_pulse = 1'b0;
    tick(1);
    buf_pulse = 1'b1; buf_clr = 1'b1;
    expect_in(SIG_BUF, 8'd1, 1, "R3");
    tick(1);
    buf_pulse = 1'b0; buf_clr = 1'b0;
    tick(1);
    buf_clr = 1'b1;
    expect_in(SIG_BUF, 8'd0, 1, "R3");
    expect_in(SIG_RTS, 8'd0, 2, "R3");
    tick(1);
    buf_clr = 1'b0;
    tick(1);

    // CTS gating and change flag: R4, R5, R8
    expect_in(SIG_TXS, 8'd1, 1, "R4");
    tick(1);
    cts = 1'b1;
    expect_in(SIG_TXS, 8'd0, 2, "R4");
    expect_in(SIG_STAT, 8'h8, 3, "R5");
    expect_in(SIG_IRQ, 8'd0, 4, "R8");
    tick(4);
    st_rd = 1'b1;
    expect_in(SIG_STAT, 8'd0, 1, "R7");
    tick(1);
    st_rd = 1'b0;
    tick(1);
    mask = 4'b1000;
    cts = 1'b0;
    expect_in(SIG_TXS, 8'd1, 2, "R4");
    expect_in(SIG_STAT, 8'h8, 3, "R5");
    expect_in(SIG_IRQ, 8'd1, 4, "R8");
    tick(4);
    st_rd = 1'b1;
    expect_in(SIG_STAT, 8'd0, 1, "R7");
    expect_in(SIG_IRQ, 8'd0, 2, "R8");
    tick(1);
    st_rd = 1'b0;
    tick(1);
    tx_busy = 1'b1;
    expect_in(SIG_TXS, 8'd0, 1, "R4");
    tick(1);
    tx_busy = 1'b0;
    dsr = 1'b1;
    expect_in(SIG_LINE, 8'h2, 2, "R6");
    expect_in(SIG_STAT, 8'h0, 3, "R6");
    tick(4);

    // modem mode: R1, R9, R6, R7
    mode = 2'b11; rts_ctrl = 1'b1; dtr_ctrl = 1'b0;
    expect_in(SIG_RTS, 8'd1, 1, "R9");
    expect_in(SIG_DTR, 8'd0, 1, "R9");
    tick(1);
    rts_ctrl = 1'b0; dtr_ctrl = 1'b1;
    expect_in(SIG_RTS, 8'd0, 1, "R9");
    expect_in(SIG_DTR, 8'd1, 1, "R9");
    tick(4);
    mask = 4'b0001;
    ri = 1'b1; dcd = 1'b1;
    expect_in(SIG_STAT, 8'h5, 3, "R6");
    expect_in(SIG_IRQ, 8'd1, 4, "R8");
    tick(4);
    dsr = 1'b0;
    tick(2);
    st_rd = 1'b1;  // read lands with the DSR change
    expect_in(SIG_STAT, 8'h2, 1, "R7");
    expect_in(SIG_IRQ, 8'd0, 2, "R8");
    tick(1);
    st_rd = 1'b0;
    tick(1);
    st_rd = 1'b1;
    expect_in(SIG_STAT, 8'h0, 1, "R7");
    tick(1);
    st_rd = 1'b0;
    tick(1);
    cts = 1'b1;
    expect_in(SIG_TXS, 8'd0, 2, "R4");
    expect_in(SIG_STAT, 8'h8, 3, "R5");
    tick(6);

    if (q_cyc.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: actual %0d pending items expected 0", q_cyc.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule